// File: doc/BRIEF.md
# Channel Status and User Bit Collector

This block sits behind a digital-audio subframe decoder. For every decoded subframe it receives the channel-status bit, the user bit, and a two-bit code for the preamble type. From these it builds a packed status word from eight consecutive frames. The word holds 16 user bits (both subframes of each frame), 8 channel-status bits and a start-of-block marker. The word is written to a status register and announced with a one-cycle strobe. It can also raise a request/acknowledge DMA handshake.

Collection starts only after the decoder reports that synchronization is done and the mode field enables acquisition. It locks onto the first block-start preamble. From then on it re-checks the preamble at the head of every eight-frame group. When that check fails, the partial group is dropped and the block waits for a new block start. A select input picks which subframe supplies the channel-status bits.

Top module: `chstat_user_collector`

## Requirements
- R1: Subframes are taken only while `sync_done_i`=1 and `acq_mode_i` is 2'b01 or 2'b11. Modes 2'b00 and 2'b10, or sync low, produce no word. Leaving the enabled state abandons any partial group, so collection restarts only at the next block start.
- R2: While not locked, collection starts only on a subframe whose preamble code is 2'b00 (block start). Subframes with codes 2'b01 (first-subframe, M) or 2'b10 (second-subframe, W) are ignored.
- R3: In each group of 8 frames, the user bit of frame f's first subframe goes to word bit 2f and that of its second subframe to bit 2f+1. The channel-status bit of frame f goes to bit 16+f. The word appears on `stat_word_o`, with `stat_valid_o` high for one cycle, right after the clock edge that takes frame 7's second subframe. At all other times the word holds.
- R4: Word bit 24 is 1 exactly when the first subframe of the group carried preamble code 2'b00.
- R5: With `c_sel_i`=0 the channel-status bits come from the first subframe of each frame. With `c_sel_i`=1 they come from the second subframe.
- R6: `dma_req_o` rises after the edge that completes a word while `dma_en_i`=1. It never rises while `dma_en_i`=0, or without a completed word.
- R7: `dma_req_o` stays high until `dma_ack_i` is seen at a clock edge, and falls after that edge. A word that completes while a request is pending overwrites the register, and collection never waits on the request.
- R8: Once locked, the first subframe of every group must carry code 2'b00 or 2'b01. Any other code pulses `pre_err_o` for one cycle right after that edge and drops the group, and a new 2'b00 is then needed. Preambles at other positions are not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sf_valid_i | input | 1 | One-cycle strobe per decoded subframe |
| sf_pre_i | input | 2 | Preamble code: 00 block start, 01 first subframe, 10 second subframe |
| sf_c_i | input | 1 | Channel-status bit of the subframe |
| sf_u_i | input | 1 | User bit of the subframe |
| sync_done_i | input | 1 | Decoder synchronization complete |
| acq_mode_i | input | 2 | Acquisition mode; 01 or 11 enables |
| c_sel_i | input | 1 | Channel-status source: 0 first subframe, 1 second |
| dma_en_i | input | 1 | Enable DMA request on word completion |
| dma_ack_i | input | 1 | DMA acknowledge |
| stat_word_o | output | 3*N_FRAMES+1 (25) | Packed status word |
| stat_valid_o | output | 1 | One-cycle strobe when the word is written |
| dma_req_o | output | 1 | Pending DMA request |
| pre_err_o | output | 1 | One-cycle pulse on a failed group-head preamble check |

## Verification
Every result is one register behind its cause. The word, its strobe, the request and the preamble-error pulse all change at the same edge that takes the deciding subframe or acknowledge. So the bench drives each subframe for one cycle from a falling edge and reads the outputs at the next falling edge, half a period after the edge that updated them. A monitor counts strobes and error pulses 1 ns after each rising edge. This lets the no-word and no-error cases be judged by unchanged counts once a whole group has been sent.

// File: rtl/cu_pkg.sv
package cu_pkg;
  typedef enum logic [1:0] {
    PRE_B = 2'b00,
    PRE_M = 2'b01,
    PRE_W = 2'b10,
    PRE_X = 2'b11
  } pre_e;
endpackage

// File: rtl/cu_frame_tracker.sv
module cu_frame_tracker
  import cu_pkg::*;
#(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sf_valid_i,
  input  pre_e             pre_i,
  input  logic             acq_ok_i,
  output logic             accept_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             half_o,
  output logic             sob_o,
  output logic             complete_o,
  output logic             err_o
);
  logic             active_q, half_q, sob_q, err_q;
  logic [IDX_W-1:0] idx_q;
  logic             is_first, grp_head, chk_fail, accept;

  always_comb begin
    is_first = (pre_i == PRE_B) || (pre_i == PRE_M);
    grp_head = active_q && !half_q && (idx_q == '0);
    chk_fail = 1'b0;
    accept   = 1'b0;
    if (sf_valid_i && acq_ok_i) begin
      if (!active_q)                accept   = (pre_i == PRE_B);
      else if (grp_head && !is_first) chk_fail = 1'b1;
      else                          accept   = 1'b1;
    end
  end

  assign complete_o = accept && half_q && (idx_q == IDX_W'(N_FRAMES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      idx_q    <= '0;
      sob_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= chk_fail;
      if (!acq_ok_i || chk_fail) begin
        active_q <= 1'b0;
        half_q   <= 1'b0;
        idx_q    <= '0;
      end else if (accept) begin
        active_q <= 1'b1;
        if (half_q) begin
          half_q <= 1'b0;
          idx_q  <= (idx_q == IDX_W'(N_FRAMES - 1)) ? '0 : idx_q + 1'b1;
        end else begin
          half_q <= 1'b1;
          if (idx_q == '0) sob_q <= (pre_i == PRE_B);
        end
      end
    end
  end

  assign accept_o = accept;
  assign idx_o    = idx_q;
  assign half_o   = half_q;
  assign sob_o    = sob_q;
  assign err_o    = err_q;

  // R1
  drop_on_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acq_ok_i |=> !active_q);
  // R8
  err_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> ($past(active_q) && !active_q));
endmodule

// File: rtl/cu_bit_packer.sv
module cu_bit_packer #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES),
  localparam int U_W   = 2 * N_FRAMES,
  localparam int C_W   = N_FRAMES,
  localparam int W_W   = U_W + C_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             half_i,
  input  logic             c_sel_i,
  input  logic             c_bit_i,
  input  logic             u_bit_i,
  input  logic             sob_i,
  input  logic             complete_i,
  output logic [W_W-1:0]   word_o,
  output logic             word_valid_o
);
  logic [U_W-1:0] u_q, u_nxt;
  logic [C_W-1:0] c_q, c_nxt;
  logic [W_W-1:0] word_q;
  logic           valid_q;

  always_comb begin
    u_nxt = u_q;
    c_nxt = c_q;
    if (accept_i) begin
      u_nxt[{idx_i, half_i}] = u_bit_i;
      if (half_i == c_sel_i) c_nxt[idx_i] = c_bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      u_q     <= '0;
      c_q     <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      u_q     <= u_nxt;
      c_q     <= c_nxt;
      valid_q <= complete_i;
      if (complete_i) word_q <= {sob_i, c_nxt, u_nxt};
    end
  end

  assign word_o       = word_q;
  assign word_valid_o = valid_q;

  // R3
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !complete_i |=> ($stable(word_q) && !valid_q));
endmodule

// File: rtl/cu_dma_req.sv
module cu_dma_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic complete_i,
  input  logic dma_en_i,
  input  logic ack_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     req_q <= 1'b0;
    else if (complete_i && dma_en_i) req_q <= 1'b1;
    else if (ack_i)                  req_q <= 1'b0;
  end

  assign req_o = req_q;

  // R6
  req_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete_i && dma_en_i) |=> req_q);
  // R6
  no_spurious_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(complete_i && dma_en_i));
  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> req_q);
endmodule

// File: rtl/chstat_user_collector.sv
module chstat_user_collector
  import cu_pkg::*;
#(
  parameter int N_FRAMES = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sf_valid_i,
  input  logic [1:0]            sf_pre_i,
  input  logic                  sf_c_i,
  input  logic                  sf_u_i,
  input  logic                  sync_done_i,
  input  logic [1:0]            acq_mode_i,
  input  logic                  c_sel_i,
  input  logic                  dma_en_i,
  input  logic                  dma_ack_i,
  output logic [3*N_FRAMES:0]   stat_word_o,
  output logic                  stat_valid_o,
  output logic                  dma_req_o,
  output logic                  pre_err_o
);
  localparam int IDX_W = $clog2(N_FRAMES);

  logic             acq_ok, accept, half, sob, complete;
  logic [IDX_W-1:0] idx;

  // modes 01 and 11 enable
  assign acq_ok = sync_done_i && acq_mode_i[0];

  cu_frame_tracker #(.N_FRAMES(N_FRAMES)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sf_valid_i (sf_valid_i),
    .pre_i      (pre_e'(sf_pre_i)),
    .acq_ok_i   (acq_ok),
    .accept_o   (accept),
    .idx_o      (idx),
    .half_o     (half),
    .sob_o      (sob),
    .complete_o (complete),
    .err_o      (pre_err_o)
  );

  cu_bit_packer #(.N_FRAMES(N_FRAMES)) u_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .idx_i        (idx),
    .half_i       (half),
    .c_sel_i      (c_sel_i),
    .c_bit_i      (sf_c_i),
    .u_bit_i      (sf_u_i),
    .sob_i        (sob),
    .complete_i   (complete),
    .word_o       (stat_word_o),
    .word_valid_o (stat_valid_o)
  );

  cu_dma_req u_dma (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .complete_i (complete),
    .dma_en_i   (dma_en_i),
    .ack_i      (dma_ack_i),
    .req_o      (dma_req_o)
  );
endmodule

// File: tb/tb_chstat_user_collector.sv
module tb_chstat_user_collector;
  localparam int NF = 8;
  localparam int WW = 3 * NF + 1;
  localparam logic [1:0] PB = 2'b00, PM = 2'b01, PW = 2'b10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic sf_valid = 0, sf_c = 0, sf_u = 0, sync_done = 0, c_sel = 0, dma_en = 0, dma_ack = 0;
  logic [1:0] sf_pre = PM, acq_mode = 2'b00;
  logic [WW-1:0] stat_word;
  logic stat_valid, dma_req, pre_err;

  int total = 0, bad = 0, nword = 0, nerr = 0;

  chstat_user_collector #(.N_FRAMES(NF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sf_valid_i(sf_valid), .sf_pre_i(sf_pre),
    .sf_c_i(sf_c), .sf_u_i(sf_u), .sync_done_i(sync_done), .acq_mode_i(acq_mode),
    .c_sel_i(c_sel), .dma_en_i(dma_en), .dma_ack_i(dma_ack),
    .stat_word_o(stat_word), .stat_valid_o(stat_valid), .dma_req_o(dma_req),
    .pre_err_o(pre_err)
  );

  always @(posedge clk) begin
    #1;
    if (stat_valid) nword++;
    if (pre_err) nerr++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] exp_word(input bit sob, input logic [7:0] ca, cb, ua, ub,
                                             input bit sel);
    logic [15:0] u;
    for (int f = 0; f < NF; f++) begin
      u[2*f]   = ua[f];
      u[2*f+1] = ub[f];
    end
    return {sob, sel ? cb : ca, u};
  endfunction

  task automatic send_sf(input logic [1:0] pre, input logic c, input logic u);
    @(negedge clk);
    sf_valid = 1; sf_pre = pre; sf_c = c; sf_u = u;
    @(negedge clk);
    sf_valid = 0;
  endtask

  task automatic send_group(input logic [1:0] first, input logic [7:0] ca, cb, ua, ub,
                            input bit mid_w);
    for (int f = 0; f < NF; f++) begin
      send_sf((f == 0) ? first : ((mid_w && f == 3) ? PW : PM), ca[f], ua[f]);
      send_sf(PW, cb[f], ub[f]);
    end
  endtask

  task automatic unlock();
    @(negedge clk); acq_mode = 2'b00;
    @(negedge clk); acq_mode = 2'b01;
  endtask

  task automatic t_reset();
    chk("R3 reset word", 32'(stat_word), 0);
    chk("R3 reset valid", 32'(stat_valid), 0);
    chk("R6 reset req", 32'(dma_req), 0);
    chk("R8 reset err", 32'(pre_err), 0);
  endtask

  task automatic t_gating();
    int n0;
    sync_done = 1; acq_mode = 2'b00; n0 = nword;
    send_group(PB, 8'h11, 8'h22, 8'h33, 8'h44, 0);
    chk("R1 mode 00", 32'(nword - n0), 0);
    acq_mode = 2'b10;
    send_group(PB, 8'h11, 8'h22, 8'h33, 8'h44, 0);
    chk("R1 mode 10", 32'(nword - n0), 0);
    acq_mode = 2'b01; sync_done = 0;
    send_group(PB, 8'h11, 8'h22, 8'h33, 8'h44, 0);
    chk("R1 no sync", 32'(nword - n0), 0);
    chk("R1 word untouched", 32'(stat_word), 0);
    sync_done = 1; acq_mode = 2'b11;
    send_group(PB, 8'h5A, 8'hC3, 8'h0F, 8'hF0, 0);
    chk("R1 mode 11 word", 32'(stat_word), 32'(exp_word(1, 8'h5A, 8'hC3, 8'h0F, 8'hF0, 0)));
    // partial group then disable: must need a new block start
    n0 = nword;
    for (int f = 0; f < 4; f++) begin send_sf(f == 0 ? PB : PM, 1, 1); send_sf(PW, 0, 0); end
    unlock();
    send_group(PM, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 0);
    chk("R1 partial dropped", 32'(nword - n0), 0);
  endtask

  task automatic t_start();
    int n0;
    unlock(); n0 = nword; c_sel = 0;
    send_sf(PM, 1, 1); send_sf(PW, 1, 1); send_sf(PW, 1, 1);
    send_group(PB, 8'h96, 8'h69, 8'hA5, 8'h3C, 0);
    chk("R2 one word", 32'(nword - n0), 1);
    chk("R2 aligned to B", 32'(stat_word), 32'(exp_word(1, 8'h96, 8'h69, 8'hA5, 8'h3C, 0)));
  endtask

  task automatic t_layout();
    c_sel = 0;
    send_group(PM, 8'hA5, 8'h3C, 8'h96, 8'h0F, 0);
    chk("R3 strobe", 32'(stat_valid), 1);
    chk("R3 layout", 32'(stat_word), 32'(exp_word(0, 8'hA5, 8'h3C, 8'h96, 8'h0F, 0)));
    chk("R4 sob clear", 32'(stat_word[WW-1]), 0);
    @(negedge clk);
    chk("R3 strobe one cycle", 32'(stat_valid), 0);
    send_group(PB, 8'h01, 8'h80, 8'hFE, 8'h7F, 0);
    chk("R4 sob set", 32'(stat_word[WW-1]), 1);
    chk("R4 word", 32'(stat_word), 32'(exp_word(1, 8'h01, 8'h80, 8'hFE, 8'h7F, 0)));
    c_sel = 1;
    send_group(PM, 8'hA5, 8'h3C, 8'h96, 8'h0F, 0);
    chk("R5 C from second", 32'(stat_word), 32'(exp_word(0, 8'hA5, 8'h3C, 8'h96, 8'h0F, 1)));
    c_sel = 0;
  endtask

  task automatic t_dma();
    int n0;
    dma_en = 0;
    send_group(PM, 8'h12, 8'h34, 8'h56, 8'h78, 0);
    chk("R6 no req when off", 32'(dma_req), 0);
    dma_en = 1;
    send_group(PM, 8'h9A, 8'hBC, 8'hDE, 8'hF0, 0);
    chk("R6 req raised", 32'(dma_req), 1);
    repeat (5) @(negedge clk);
    chk("R7 req held", 32'(dma_req), 1);
    n0 = nword;
    send_group(PM, 8'h0E, 8'hE0, 8'h3C, 8'hC3, 0);
    chk("R7 no stall", 32'(nword - n0), 1);
    chk("R7 overwrite", 32'(stat_word), 32'(exp_word(0, 8'h0E, 8'hE0, 8'h3C, 8'hC3, 0)));
    chk("R7 still pending", 32'(dma_req), 1);
    dma_ack = 1;
    @(negedge clk); dma_ack = 0;
    chk("R7 ack clears", 32'(dma_req), 0);
    dma_en = 0;
  endtask

  task automatic t_check();
    int n0, e0;
    e0 = nerr;
    send_group(PM, 8'h55, 8'hAA, 8'h33, 8'hCC, 1);
    chk("R8 mid W unchecked", 32'(stat_word), 32'(exp_word(0, 8'h55, 8'hAA, 8'h33, 8'hCC, 0)));
    chk("R8 no err mid", 32'(nerr - e0), 0);
    n0 = nword;
    send_sf(PW, 1, 1);
    chk("R8 err pulse", 32'(pre_err), 1);
    send_sf(PW, 0, 0);
    for (int f = 1; f < NF; f++) begin send_sf(PM, 1, 0); send_sf(PW, 0, 1); end
    chk("R8 group dropped", 32'(nword - n0), 0);
    chk("R8 one err", 32'(nerr - e0), 1);
    send_group(PB, 8'hC0, 8'h03, 8'h18, 8'h81, 0);
    chk("R8 relock on B", 32'(stat_word), 32'(exp_word(1, 8'hC0, 8'h03, 8'h18, 8'h81, 0)));
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gating();
    t_start();
    t_layout();
    t_dma();
    t_check();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule